// File: doc/BRIEF.md
# Microcontroller to ISA Byte Mailbox Bridge

This block passes single bytes in both directions between a small microcontroller's external bus and an 8-bit ISA I/O slave port. Each direction has a one-byte mailbox with a full flag.

The host writes the inbound byte, and the bridge pulls the microcontroller's active-low interrupt line to announce it. The microcontroller writes the outbound byte. The host learns that this byte is waiting only by polling a status register. No host interrupt is raised.

When a host access cannot complete, the bridge lengthens the ISA cycle by pulling the ready line low. This happens when the host writes while the inbound byte is still full, or reads data while the outbound byte is empty. The stretch lasts at most a fixed number of bus clocks, so the bus can never hang.

The whole block runs on the ISA bus clock. The microcontroller strobes pass through two-flop synchronisers before any register changes. The microcontroller's address and data must stay stable while a strobe is low and for four bus clocks after it rises.

Top module: `mbox_bridge`

## Requirements
- R1: The ISA side responds only when `isaAen` is 0 and `isaAddr[9:1]` equals `ISA_BASE[9:1]` (default base 0x300). Data is at even address base+0 and status at base+1. Any other access changes nothing and leaves `isaDataOe` at 0.
- R2: A host write to the data register while the inbound byte is empty stores the byte. From the following clock, status bit 1 reads 1 and `mcuIntN` is 0.
- R3: A microcontroller read of its data register (default address 0x8000) returns the inbound byte. No later than the fourth clock after `mcuRdN` rises, status bit 1 reads 0 and `mcuIntN` is 1.
- R4: A microcontroller write of its data register while the outbound byte is empty stores the byte. Status bit 0 becomes 1 at the third falling clock edge after `mcuWrN` goes low, and not earlier.
- R5: A host read of the data register while the outbound byte is full returns that byte. Status bit 0 reads 0 from the clock after `isaIorN` rises.
- R6: On both sides, the status register (base+1) reads {6'b0, inboundFull, outboundFull}. Bit 0 is the outbound flag (microcontroller to host) and bit 1 is the inbound flag (host to microcontroller).
- R7: A host write while the inbound byte is full holds `isaRdyPullLow` at 1 until the microcontroller has read the old byte. Then it stores the new byte without losing the old one.
- R8: A host data read while the outbound byte is empty holds `isaRdyPullLow` at 1 until the microcontroller writes a byte. That byte is then presented on `isaRdData`.
- R9: `isaRdyPullLow` stays 1 for at most `WAIT_MAX` consecutive clocks. If that wait expires, a pending host write is dropped and the stored byte is kept.
- R10: A microcontroller write while the outbound byte is full is ignored, and the byte already held is kept.
- R11: While `resetDrv` is 1, both full flags clear, `mcuIntN` goes to 1 and `isaRdyPullLow` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | ISA bus clock; all state is clocked by it |
| resetDrv | input | 1 | Active-high global clear |
| mcuAddr | input | 16 | Microcontroller address |
| mcuRdN | input | 1 | Microcontroller read strobe, active low, asynchronous |
| mcuWrN | input | 1 | Microcontroller write strobe, active low, asynchronous |
| mcuWrData | input | 8 | Byte written by the microcontroller |
| mcuRdData | output | 8 | Byte returned to the microcontroller |
| mcuDataOe | output | 1 | Drive enable for the microcontroller data bus |
| mcuIntN | output | 1 | Active-low interrupt toward the microcontroller |
| isaAddr | input | 10 | ISA I/O address |
| isaAen | input | 1 | DMA address enable; 1 blocks all decoding |
| isaIorN | input | 1 | ISA I/O read strobe, active low |
| isaIowN | input | 1 | ISA I/O write strobe, active low |
| isaWrData | input | 8 | Byte written by the host |
| isaRdData | output | 8 | Byte returned to the host |
| isaDataOe | output | 1 | Drive enable for the ISA data bus |
| isaRdyPullLow | output | 1 | 1 pulls the open-drain ready line low; the line is never driven high |

## Verification
An ISA write commits on the clock edge that samples its strobe low, so the interrupt and status bit 1 are checked at the next falling edge. A microcontroller write sees two synchroniser flops and one edge-detect stage, so status bit 0 is checked at the second falling edge, where it must still be 0, and at the third, where it must be 1. Clears that follow a strobe release are checked only after the four-clock window of R3, or at the next clock for R5. For wait states, the bench samples the ready pull-down at every falling edge and counts the cycles during which it is held.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
    logic clearIn;
    logic clearOut;
  } mboxStrobes_t;

  typedef enum logic [1:0] {
    HOST_IDLE,
    HOST_WAIT_WR,
    HOST_WAIT_RD,
    HOST_HOLD
  } hostState_t;

endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : gBit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], asyncIn[b]};
      end
      assign syncOut[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int WAIT_MAX = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mcuRdSync,
  input  logic         mcuWrSync,
  input  logic         mcuSelData,
  input  logic         isaSel,
  input  logic         isaSelData,
  input  logic         isaIorN,
  input  logic         isaIowN,
  input  logic         inFull,
  input  logic         outFull,
  output mboxStrobes_t strb,
  output logic         rdyPullLow
);

  localparam int CNT_W = (WAIT_MAX > 2) ? $clog2(WAIT_MAX) : 1;
  localparam int RUN_W = $clog2(WAIT_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_MAX - 1);

  hostState_t hostState, hostNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic readTook, readTookNext;
  logic iorPrev, iowPrev;
  logic iorStart, iowStart;

  logic rdPrev, wrPrev;
  logic rdFall, rdRise, wrFall;
  logic mcuRdTook;

  assign iorStart = isaSel && !isaIorN && iorPrev;
  assign iowStart = isaSel && !isaIowN && iowPrev;

  always_comb begin
    hostNext     = hostState;
    waitCntNext  = waitCnt;
    readTookNext = readTook;
    strb.loadIn   = 1'b0;
    strb.clearOut = 1'b0;
    unique case (hostState)
      HOST_IDLE: begin
        waitCntNext = '0;
        if (iowStart) begin
          if (isaSelData && inFull) begin
            hostNext = HOST_WAIT_WR;
          end else begin
            strb.loadIn = isaSelData;
            hostNext    = HOST_HOLD;
          end
        end else if (iorStart) begin
          if (isaSelData && !outFull) begin
            hostNext = HOST_WAIT_RD;
          end else begin
            readTookNext = isaSelData;
            hostNext     = HOST_HOLD;
          end
        end
      end
      HOST_WAIT_WR: begin
        if (!inFull) begin
          strb.loadIn = 1'b1;
          hostNext    = HOST_HOLD;
        end else if (waitCnt == CNT_LAST) begin
          hostNext = HOST_HOLD;
        end else begin
          waitCntNext = waitCnt + 1'b1;
        end
      end
      HOST_WAIT_RD: begin
        if (outFull) begin
          readTookNext = 1'b1;
          hostNext     = HOST_HOLD;
        end else if (waitCnt == CNT_LAST) begin
          readTookNext = 1'b0;
          hostNext     = HOST_HOLD;
        end else begin
          waitCntNext = waitCnt + 1'b1;
        end
      end
      HOST_HOLD: begin
        if (isaIorN && isaIowN) begin
          strb.clearOut = readTook;
          readTookNext  = 1'b0;
          hostNext      = HOST_IDLE;
        end
      end
      default: hostNext = HOST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hostState <= HOST_IDLE;
      waitCnt   <= '0;
      readTook  <= 1'b0;
      iorPrev   <= 1'b1;
      iowPrev   <= 1'b1;
    end else begin
      hostState <= hostNext;
      waitCnt   <= waitCntNext;
      readTook  <= readTookNext;
      iorPrev   <= isaIorN;
      iowPrev   <= isaIowN;
    end
  end

  assign rdyPullLow = (hostState == HOST_WAIT_WR) || (hostState == HOST_WAIT_RD);

  assign rdFall = !mcuRdSync && rdPrev;
  assign rdRise = mcuRdSync && !rdPrev;
  assign wrFall = !mcuWrSync && wrPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPrev    <= 1'b1;
      wrPrev    <= 1'b1;
      mcuRdTook <= 1'b0;
    end else begin
      rdPrev <= mcuRdSync;
      wrPrev <= mcuWrSync;
      if (rdFall)      mcuRdTook <= mcuSelData && inFull;
      else if (rdRise) mcuRdTook <= 1'b0;
    end
  end

  assign strb.loadOut = wrFall && mcuSelData && !outFull;
  assign strb.clearIn = rdRise && mcuRdTook;

  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (rst)             lowRun <= '0;
    else if (rdyPullLow) lowRun <= lowRun + 1'b1;
    else                 lowRun <= '0;
  end

  AST_RDY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    lowRun <= RUN_W'(WAIT_MAX)); // R9

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mboxStrobes_t      strb,
  input  logic [DATA_W-1:0] mcuWrData,
  input  logic [DATA_W-1:0] isaWrData,
  input  logic              mcuAddrLsb,
  input  logic              isaAddrLsb,
  output logic              inFull,
  output logic              outFull,
  output logic [DATA_W-1:0] mcuRdData,
  output logic [DATA_W-1:0] isaRdData
);

  logic [DATA_W-1:0] inData, outData;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      inData <= '0;
      inFull <= 1'b0;
    end else if (strb.clearIn) begin
      inFull <= 1'b0;
    end else if (strb.loadIn && !inFull) begin
      inData <= isaWrData;
      inFull <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
      outFull <= 1'b0;
    end else if (strb.clearOut) begin
      outFull <= 1'b0;
    end else if (strb.loadOut && !outFull) begin
      outData <= mcuWrData;
      outFull <= 1'b1;
    end
  end

  assign statusWord = {{(DATA_W-2){1'b0}}, inFull, outFull};
  assign mcuRdData  = mcuAddrLsb ? statusWord : inData;
  assign isaRdData  = isaAddrLsb ? statusWord : outData;

  AST_IN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (inFull && !strb.clearIn) |=> $stable(inData)); // R7

  AST_OUT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (outFull && !strb.clearOut) |=> $stable(outData)); // R10

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter logic [15:0] MCU_BASE = 16'h8000,
  parameter logic [9:0]  ISA_BASE = 10'h300,
  parameter int          WAIT_MAX = 8
) (
  input  logic        sysClk,
  input  logic        resetDrv,
  input  logic [15:0] mcuAddr,
  input  logic        mcuRdN,
  input  logic        mcuWrN,
  input  logic [7:0]  mcuWrData,
  output logic [7:0]  mcuRdData,
  output logic        mcuDataOe,
  output logic        mcuIntN,
  input  logic [9:0]  isaAddr,
  input  logic        isaAen,
  input  logic        isaIorN,
  input  logic        isaIowN,
  input  logic [7:0]  isaWrData,
  output logic [7:0]  isaRdData,
  output logic        isaDataOe,
  output logic        isaRdyPullLow
);

  mboxStrobes_t strb;
  logic [1:0] mcuStrbSync;
  logic mcuSel, isaSel;
  logic inFull, outFull;

  assign mcuSel = (mcuAddr[15:1] == MCU_BASE[15:1]);
  assign isaSel = !isaAen && (isaAddr[9:1] == ISA_BASE[9:1]);

  mbox_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(1'b1)) uSync (
    .clk     (sysClk),
    .rst     (resetDrv),
    .asyncIn ({mcuWrN, mcuRdN}),
    .syncOut (mcuStrbSync)
  );

  mbox_ctrl #(.WAIT_MAX(WAIT_MAX)) uCtrl (
    .clk        (sysClk),
    .rst        (resetDrv),
    .mcuRdSync  (mcuStrbSync[0]),
    .mcuWrSync  (mcuStrbSync[1]),
    .mcuSelData (mcuSel && !mcuAddr[0]),
    .isaSel     (isaSel),
    .isaSelData (!isaAddr[0]),
    .isaIorN    (isaIorN),
    .isaIowN    (isaIowN),
    .inFull     (inFull),
    .outFull    (outFull),
    .strb       (strb),
    .rdyPullLow (isaRdyPullLow)
  );

  mbox_datapath #(.DATA_W(8)) uData (
    .clk        (sysClk),
    .rst        (resetDrv),
    .strb       (strb),
    .mcuWrData  (mcuWrData),
    .isaWrData  (isaWrData),
    .mcuAddrLsb (mcuAddr[0]),
    .isaAddrLsb (isaAddr[0]),
    .inFull     (inFull),
    .outFull    (outFull),
    .mcuRdData  (mcuRdData),
    .isaRdData  (isaRdData)
  );

  assign mcuIntN   = !inFull;
  assign mcuDataOe = mcuSel && !mcuRdN;
  assign isaDataOe = isaSel && !isaIorN;

  AST_INT_ON_LOAD: assert property (@(posedge sysClk) disable iff (resetDrv)
    strb.loadIn |=> !mcuIntN); // R2

  AST_INT_OFF_ON_READ: assert property (@(posedge sysClk) disable iff (resetDrv)
    strb.clearIn |=> mcuIntN); // R3

  AST_RESET_CLEAR: assert property (@(posedge sysClk)
    resetDrv |=> (mcuIntN && !isaRdyPullLow)); // R11

endmodule

// File: tb/mbox_bridge_test.sv
`timescale 1ns/1ps
module mbox_bridge_test;

  localparam int WAIT_T = 16;

  logic        sysClk = 1'b0;
  logic        resetDrv = 1'b1;
  logic [15:0] mcuAddr = 16'h0000;
  logic        mcuRdN = 1'b1;
  logic        mcuWrN = 1'b1;
  logic [7:0]  mcuWrData = 8'h00;
  logic [7:0]  mcuRdData;
  logic        mcuDataOe;
  logic        mcuIntN;
  logic [9:0]  isaAddr = 10'h000;
  logic        isaAen = 1'b0;
  logic        isaIorN = 1'b1;
  logic        isaIowN = 1'b1;
  logic [7:0]  isaWrData = 8'h00;
  logic [7:0]  isaRdData;
  logic        isaDataOe;
  logic        isaRdyPullLow;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] got;

  always #5 sysClk = ~sysClk;

  mbox_bridge #(.MCU_BASE(16'h8000), .ISA_BASE(10'h300), .WAIT_MAX(WAIT_T)) uut (
    .sysClk, .resetDrv, .mcuAddr, .mcuRdN, .mcuWrN, .mcuWrData, .mcuRdData,
    .mcuDataOe, .mcuIntN, .isaAddr, .isaAen, .isaIorN, .isaIowN, .isaWrData,
    .isaRdData, .isaDataOe, .isaRdyPullLow
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic isaWrite(input logic [9:0] a, input logic [7:0] d, input logic aen);
    @(negedge sysClk);
    isaAddr = a; isaWrData = d; isaAen = aen; isaIowN = 1'b0;
    repeat (2) @(negedge sysClk);
    while (isaRdyPullLow) @(negedge sysClk);
    isaIowN = 1'b1;
    repeat (2) @(negedge sysClk);
    isaAen = 1'b0;
  endtask

  task automatic isaRead(input logic [9:0] a, input logic aen, output logic [7:0] d);
    @(negedge sysClk);
    isaAddr = a; isaAen = aen; isaIorN = 1'b0;
    repeat (2) @(negedge sysClk);
    while (isaRdyPullLow) @(negedge sysClk);
    d = isaRdData;
    isaIorN = 1'b1;
    repeat (2) @(negedge sysClk);
    isaAen = 1'b0;
  endtask

  task automatic mcuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge sysClk);
    mcuAddr = a; mcuWrData = d; mcuWrN = 1'b0;
    repeat (4) @(negedge sysClk);
    mcuWrN = 1'b1;
    repeat (4) @(negedge sysClk);
  endtask

  task automatic mcuRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge sysClk);
    mcuAddr = a; mcuRdN = 1'b0;
    repeat (3) @(negedge sysClk);
    d = mcuRdData;
    mcuRdN = 1'b1;
    repeat (4) @(negedge sysClk);
  endtask

  task automatic testReset;
    check("R11 intN after reset", mcuIntN, 1);
    check("R11 ready after reset", isaRdyPullLow, 0);
    isaRead(10'h301, 1'b0, got);
    check("R11 R6 status after reset", got, 8'h00);
  endtask

  task automatic testDecode;
    isaWrite(10'h302, 8'hEE, 1'b0);
    check("R1 other address ignored", mcuIntN, 1);
    isaWrite(10'h300, 8'hEE, 1'b1);
    check("R1 aen high ignored", mcuIntN, 1);
    @(negedge sysClk);
    isaAddr = 10'h300; isaAen = 1'b1; isaIorN = 1'b0;
    @(negedge sysClk);
    check("R1 no drive with aen high", isaDataOe, 0);
    isaAen = 1'b0;
    @(negedge sysClk);
    check("R1 drive when selected", isaDataOe, 1);
    isaIorN = 1'b1;
    repeat (2) @(negedge sysClk);
  endtask

  task automatic testHostWrite;
    @(negedge sysClk);
    isaAddr = 10'h300; isaWrData = 8'hA5; isaIowN = 1'b0;
    @(negedge sysClk);
    check("R2 interrupt next clock", mcuIntN, 0);
    isaIowN = 1'b1;
    repeat (2) @(negedge sysClk);
    isaRead(10'h301, 1'b0, got);
    check("R2 R6 host status inbound", got, 8'h02);
    mcuRead(16'h8001, got);
    check("R6 mcu status inbound", got, 8'h02);
  endtask

  task automatic testMcuRead;
    mcuRead(16'h8000, got);
    check("R3 mcu data", got, 8'hA5);
    check("R3 interrupt released", mcuIntN, 1);
    isaRead(10'h301, 1'b0, got);
    check("R3 status cleared", got, 8'h00);
  endtask

  task automatic testMcuWrite;
    @(negedge sysClk);
    mcuAddr = 16'h8000; mcuWrData = 8'h3C; mcuWrN = 1'b0;
    isaAddr = 10'h301; isaIorN = 1'b0;
    repeat (2) @(negedge sysClk);
    check("R4 not yet at second edge", isaRdData, 8'h00);
    @(negedge sysClk);
    check("R4 outbound full at third edge", isaRdData, 8'h01);
    isaIorN = 1'b1;
    repeat (2) @(negedge sysClk);
    mcuWrN = 1'b1;
    repeat (4) @(negedge sysClk);
  endtask

  task automatic testMcuDropAndHostRead;
    mcuWrite(16'h8000, 8'h77);
    isaRead(10'h300, 1'b0, got);
    check("R10 R5 host reads first byte", got, 8'h3C);
    isaRead(10'h301, 1'b0, got);
    check("R5 outbound flag cleared", got, 8'h00);
  endtask

  task automatic testWaitWrite;
    isaWrite(10'h300, 8'h11, 1'b0);
    @(negedge sysClk);
    isaAddr = 10'h300; isaWrData = 8'h22; isaIowN = 1'b0;
    repeat (3) @(negedge sysClk);
    check("R7 ready held while full", isaRdyPullLow, 1);
    mcuRead(16'h8000, got);
    check("R7 old byte intact", got, 8'h11);
    check("R7 ready released", isaRdyPullLow, 0);
    isaIowN = 1'b1;
    repeat (2) @(negedge sysClk);
    mcuRead(16'h8000, got);
    check("R7 new byte stored", got, 8'h22);
  endtask

  task automatic testWaitRead;
    @(negedge sysClk);
    isaAddr = 10'h300; isaIorN = 1'b0;
    repeat (3) @(negedge sysClk);
    check("R8 ready held while empty", isaRdyPullLow, 1);
    mcuWrite(16'h8000, 8'h5A);
    check("R8 ready released", isaRdyPullLow, 0);
    check("R8 data presented", isaRdData, 8'h5A);
    isaIorN = 1'b1;
    repeat (2) @(negedge sysClk);
    isaRead(10'h301, 1'b0, got);
    check("R8 R5 flag cleared", got, 8'h00);
  endtask

  task automatic testTimeout;
    int lowCount;
    isaWrite(10'h300, 8'h33, 1'b0);
    @(negedge sysClk);
    isaAddr = 10'h300; isaWrData = 8'h44; isaIowN = 1'b0;
    lowCount = 0;
    for (int i = 0; i < 2 * WAIT_T; i++) begin
      @(negedge sysClk);
      if (isaRdyPullLow) lowCount++;
    end
    check("R9 write wait bounded", lowCount, WAIT_T);
    isaIowN = 1'b1;
    repeat (2) @(negedge sysClk);
    mcuRead(16'h8000, got);
    check("R9 dropped write kept old byte", got, 8'h33);
    @(negedge sysClk);
    isaAddr = 10'h300; isaIorN = 1'b0;
    lowCount = 0;
    for (int i = 0; i < 2 * WAIT_T; i++) begin
      @(negedge sysClk);
      if (isaRdyPullLow) lowCount++;
    end
    check("R9 read wait bounded", lowCount, WAIT_T);
    isaIorN = 1'b1;
    repeat (2) @(negedge sysClk);
  endtask

  task automatic testResetMidway;
    isaWrite(10'h300, 8'h55, 1'b0);
    mcuWrite(16'h8000, 8'h66);
    isaRead(10'h301, 1'b0, got);
    check("R6 both flags set", got, 8'h03);
    @(negedge sysClk);
    resetDrv = 1'b1;
    repeat (2) @(negedge sysClk);
    resetDrv = 1'b0;
    @(negedge sysClk);
    check("R11 interrupt cleared", mcuIntN, 1);
    isaRead(10'h301, 1'b0, got);
    check("R11 flags cleared", got, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge sysClk);
    resetDrv = 1'b0;
    @(negedge sysClk);
    testReset();
    testDecode();
    testHostWrite();
    testMcuRead();
    testMcuWrite();
    testMcuDropAndHostRead();
    testWaitWrite();
    testWaitRead();
    testTimeout();
    testResetMidway();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge sysClk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule